// File: doc/BRIEF.md
# Windowed Integer Register File with SEC-DED Protection

This block is the integer register store for a processor core that uses overlapping register windows. A shared window pointer and a 5-bit register number select one physical entry. Registers 0 to 7 are globals and are common to every window. Registers 8 to 15 are outputs, 16 to 23 are locals and 24 to 31 are inputs. The output group of window w is the same storage as the input group of window w-1, taken modulo the window count. With the default 8 windows the store holds 136 entries, built from flip-flops as a single bank.

Every entry keeps the 32-bit word plus a 7-bit single-error-correct, double-error-detect code: six Hamming check bits and one overall parity bit. The code is generated at the write port. Each of the two read ports decodes the word it reads. It corrects any single flipped bit and raises a correctable flag. It raises an uncorrectable flag when two bits are flipped or when the syndrome cannot be located. A test input XORs a chosen pattern into the codeword as it is written, so that faults can be planted on purpose.

Both read ports and the write port work in the same cycle. Reads return their result one clock after the address is presented.

Top module: `winreg_edac`

## Requirements
- R1: Global registers 1 to 7 map to the same entry whatever the window pointer is.
- R2: Register 8+i (i = 0..7) in window w is the same storage as register 24+i in window (w-1) mod 8, so window 0 outputs alias window 7 inputs.
- R3: Locals (16 to 23) and inputs (24 to 31) of a window are private to that window and are not disturbed by writes made in other windows, except through the R2 alias.
- R4: Register 0 reads as zero with both flags clear, and a write to it is discarded.
- R5: Each read port returns the data for its register, under the window pointer, on the clock after the address is presented. The two ports may read different registers in the same cycle.
- R6: When a read and a write target the same entry in the same cycle, the read returns the value held before the write.
- R7: The injection pattern is laid out as bits [31:0] = data, bits [37:32] = Hamming check bits, bit [38] = overall parity. A word stored with exactly one bit flipped, in any of the 39 positions, reads back as the original data, with the correctable flag at 1 and the uncorrectable flag at 0.
- R8: A word stored with two bits flipped reads with the uncorrectable flag at 1 and the correctable flag at 0.
- R9: A word written with no injection reads with both flags at 0.
- R10: After a synchronous reset, the read outputs and flags are zero and every entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cwp | input | 3 | Window pointer shared by all three ports |
| wr_en | input | 1 | Write strobe |
| wr_reg | input | 5 | Register number to write |
| wr_data | input | 32 | Write data |
| wr_flip | input | 39 | Test-only codeword bit flips applied at write (zero in normal use) |
| rd_a_reg | input | 5 | Register number, read port A |
| rd_b_reg | input | 5 | Register number, read port B |
| rd_a_data | output | 32 | Corrected read data, port A |
| rd_a_ce | output | 1 | Correctable error, port A |
| rd_a_ue | output | 1 | Uncorrectable error, port A |
| rd_b_data | output | 32 | Corrected read data, port B |
| rd_b_ce | output | 1 | Correctable error, port B |
| rd_b_ue | output | 1 | Uncorrectable error, port B |

## Verification
The first test writes a distinct value to every register of every window in increasing window order, so later output writes overwrite inputs of the previous window. It then reads every register of every window on both ports at once, using unrelated register numbers on each port. This separates correct aliasing from a mapping that aliases too much, too little or with the wrong wrap. A single-bit sweep over all 39 codeword positions tells data, check and parity correction apart. A sweep of two-bit pairs confirms that they are flagged rather than miscorrected. Further tests read and write the same entry in the same cycle, write to register 0, and apply a reset after the store holds data. These separate old-value reads, discarded writes and cleared storage from their faulty variants.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Number of Hamming check bits needed to cover dw data bits.
  function automatic int hbits(input int dw);
    int h;
    h = 1;
    while ((1 << h) < dw + h + 1) h++;
    return h;
  endfunction

  // Hamming position (1-based) of data bit d: the d-th position that is not a power of two.
  function automatic int hpos(input int d);
    int cnt;
    cnt = 0;
    for (int p = 3; p < 4096; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == d) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  // Mask of data bits that feed check bit k (data width up to 256).
  function automatic logic [255:0] cmask(input int dw, input int k);
    logic [255:0] m;
    m = '0;
    for (int d = 0; d < dw; d++)
      if (((hpos(d) >> k) & 1) == 1) m[d] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/rf_secded_enc.sv
module rf_secded_enc #(
  parameter int DW = 32,
  localparam int HB = rf_pkg::hbits(DW),
  localparam int TW = DW + HB + 1
) (
  input  logic [DW-1:0] data,
  output logic [TW-1:0] cw
);
  logic [HB-1:0] chk;

  for (genvar k = 0; k < HB; k++) begin : g_chk
    localparam logic [255:0] MF = rf_pkg::cmask(DW, k);
    assign chk[k] = ^(data & MF[DW-1:0]);
  end

  assign cw = {(^data) ^ (^chk), chk, data};
endmodule

// File: rtl/rf_secded_dec.sv
module rf_secded_dec #(
  parameter int DW = 32,
  localparam int HB = rf_pkg::hbits(DW),
  localparam int TW = DW + HB + 1,
  localparam int MAXP = DW + HB
) (
  input  logic [TW-1:0] cw,
  output logic [DW-1:0] data,
  output logic          ce,
  output logic          ue
);
  logic [HB-1:0] syn;
  logic [DW-1:0] flip;
  logic          odd;

  assign odd = ^cw;

  for (genvar k = 0; k < HB; k++) begin : g_syn
    localparam logic [255:0] MF = rf_pkg::cmask(DW, k);
    assign syn[k] = cw[DW+k] ^ (^(cw[DW-1:0] & MF[DW-1:0]));
  end

  for (genvar d = 0; d < DW; d++) begin : g_fix
    localparam int P = rf_pkg::hpos(d);
    assign flip[d] = odd && (syn == HB'(P));
  end

  assign data = cw[DW-1:0] ^ flip;

  always_comb begin
    ce = 1'b0;
    ue = 1'b0;
    if (odd) begin
      if (int'(syn) <= MAXP) ce = 1'b1;
      else                   ue = 1'b1;
    end else if (syn != '0) begin
      ue = 1'b1;
    end
  end

  always_comb begin
    assert_flag_excl_R8: assert (!(ce && ue));
  end
endmodule

// File: rtl/rf_winmap.sv
module rf_winmap #(
  parameter int NWIN = 8,
  localparam int WB = $clog2(NWIN),
  localparam int NPHYS = 8 + 16 * NWIN,
  localparam int PW = $clog2(NPHYS)
) (
  input  logic [WB-1:0] win,
  input  logic [4:0]    rnum,
  output logic [PW-1:0] phys
);
  logic [WB-1:0] wprev;

  assign wprev = (win == '0) ? WB'(NWIN - 1) : win - 1'b1;

  always_comb begin
    case (rnum[4:3])
      2'b00:   phys = PW'(int'(rnum[2:0]));
      2'b01:   phys = PW'(16 + 16 * int'(wprev) + int'(rnum[2:0]));
      2'b10:   phys = PW'(8 + 16 * int'(win) + int'(rnum[2:0]));
      default: phys = PW'(16 + 16 * int'(win) + int'(rnum[2:0]));
    endcase
  end
endmodule

// File: rtl/winreg_edac.sv
module winreg_edac #(
  parameter int NWIN = 8,
  parameter int DW = 32,
  localparam int WB = $clog2(NWIN),
  localparam int HB = rf_pkg::hbits(DW),
  localparam int TW = DW + HB + 1,
  localparam int NPHYS = 8 + 16 * NWIN,
  localparam int PW = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [WB-1:0] cwp,
  input  logic          wr_en,
  input  logic [4:0]    wr_reg,
  input  logic [DW-1:0] wr_data,
  input  logic [TW-1:0] wr_flip,
  input  logic [4:0]    rd_a_reg,
  input  logic [4:0]    rd_b_reg,
  output logic [DW-1:0] rd_a_data,
  output logic          rd_a_ce,
  output logic          rd_a_ue,
  output logic [DW-1:0] rd_b_data,
  output logic          rd_b_ce,
  output logic          rd_b_ue
);
  logic [TW-1:0] store [NPHYS];
  logic [PW-1:0] wphys;
  logic [TW-1:0] wcw;
  logic [4:0]    rreg [2];
  logic [DW-1:0] rdat [2];
  logic [1:0]    rce, rue;
  logic          warm1, warm2;

  assign rreg[0] = rd_a_reg;
  assign rreg[1] = rd_b_reg;

  rf_winmap #(.NWIN(NWIN)) u_wmap (.win(cwp), .rnum(wr_reg), .phys(wphys));
  rf_secded_enc #(.DW(DW)) u_enc (.data(wr_data), .cw(wcw));

  // Single write bank; register 0 of the globals is never written.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPHYS; i++) store[i] <= '0;
    end else if (wr_en && (wphys != '0)) begin
      store[wphys] <= wcw ^ wr_flip;
    end
  end

  always_ff @(posedge clk) begin
    warm1 <= !rst;
    warm2 <= !rst && warm1;
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [PW-1:0] rphys;
    logic [DW-1:0] ddat;
    logic          dce, due;

    rf_winmap #(.NWIN(NWIN)) u_rmap (.win(cwp), .rnum(rreg[p]), .phys(rphys));
    rf_secded_dec #(.DW(DW)) u_dec (.cw(store[rphys]), .data(ddat), .ce(dce), .ue(due));

    always_ff @(posedge clk) begin
      if (rst) begin
        rdat[p] <= '0;
        rce[p]  <= 1'b0;
        rue[p]  <= 1'b0;
      end else begin
        rdat[p] <= ddat;
        rce[p]  <= dce;
        rue[p]  <= due;
      end
    end

    assert_zero_reg_R4: assert property (@(posedge clk) disable iff (rst)
      (rreg[p] == 5'd0) |=> (rdat[p] == '0 && !rce[p] && !rue[p]));

    assert_flags_excl_R8: assert property (@(posedge clk) disable iff (rst)
      !(rce[p] && rue[p]));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (warm2 && !$past(wr_en) && $stable(rreg[p]) && $stable(cwp)) |=> $stable(rdat[p]));
  end

  assert_entry0_clear_R4: assert property (@(posedge clk) disable iff (rst)
    store[0] == '0);

  assign rd_a_data = rdat[0];
  assign rd_a_ce   = rce[0];
  assign rd_a_ue   = rue[0];
  assign rd_b_data = rdat[1];
  assign rd_b_ce   = rce[1];
  assign rd_b_ue   = rue[1];
endmodule

// File: tb/winreg_edac_tb_top.sv
module winreg_edac_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cwp = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_reg = '0;
  logic [31:0] wr_data = '0;
  logic [38:0] wr_flip = '0;
  logic [4:0]  rd_a_reg = '0, rd_b_reg = '0;
  logic [31:0] rd_a_data, rd_b_data;
  logic        rd_a_ce, rd_a_ue, rd_b_ce, rd_b_ue;

  int nchk = 0, nbad = 0;
  bit done = 0;
  logic [31:0] model [256];

  always #2.5 clk = ~clk;

  winreg_edac dut_i (
    .clk(clk), .rst(rst), .cwp(cwp), .wr_en(wr_en), .wr_reg(wr_reg),
    .wr_data(wr_data), .wr_flip(wr_flip), .rd_a_reg(rd_a_reg), .rd_b_reg(rd_b_reg),
    .rd_a_data(rd_a_data), .rd_a_ce(rd_a_ce), .rd_a_ue(rd_a_ue),
    .rd_b_data(rd_b_data), .rd_b_ce(rd_b_ce), .rd_b_ue(rd_b_ue));

  // Canonical key from R1/R2: outputs of w are named by the inputs of w-1.
  function automatic int key(input int w, input int r);
    if (r < 8)  return r;
    if (r < 16) return ((w + 7) % 8) * 32 + r + 16;
    return w * 32 + r;
  endfunction

  function automatic logic [31:0] pat(input int w, input int r);
    return (32'h9E37_79B9 * (w * 32 + r + 1)) ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int w, input int r, input logic [31:0] d, input logic [38:0] f);
    @(negedge clk);
    cwp = 3'(w); wr_en = 1'b1; wr_reg = 5'(r); wr_data = d; wr_flip = f;
    @(negedge clk);
    wr_en = 1'b0; wr_flip = '0;
  endtask

  task automatic rd2(input int w, input int ra, input int rb);
    @(negedge clk);
    cwp = 3'(w); rd_a_reg = 5'(ra); rd_b_reg = 5'(rb);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: outputs clear after reset, storage reads zero
    check("R10 outputs after reset", {rd_a_data, rd_b_data}, 64'd0);
    check("R10 flags after reset", {rd_a_ce, rd_a_ue, rd_b_ce, rd_b_ue}, 64'd0);
    rd2(5, 17, 9);
    check("R10 entry zero", {rd_a_data, rd_b_data}, 64'd0);

    // Fill every register of every window (R1 R2 R3)
    for (int w = 0; w < 8; w++)
      for (int r = 1; r < 32; r++) begin
        wr(w, r, pat(w, r), '0);
        model[key(w, r)] = pat(w, r);
      end

    // Read sweep on both ports with unrelated register numbers (R1 R2 R3 R5 R9)
    for (int w = 0; w < 8; w++)
      for (int r = 0; r < 32; r++) begin
        int rb;
        rb = (r * 7 + 3) % 32;
        rd2(w, r, rb);
        check($sformatf("R1 R2 R3 R5 port A w%0d r%0d", w, r), rd_a_data, model[key(w, r)]);
        check($sformatf("R1 R2 R3 R5 port B w%0d r%0d", w, rb), rd_b_data, model[key(w, rb)]);
        check("R9 clean flags", {rd_a_ce, rd_a_ue, rd_b_ce, rd_b_ue}, 64'd0);
      end

    // R2 wrap: window 0 outputs are window 7 inputs
    wr(0, 10, 32'hC0FF_EE01, '0);
    rd2(7, 26, 26);
    check("R2 wrap alias", rd_a_data, 32'hC0FF_EE01);
    model[key(0, 10)] = 32'hC0FF_EE01;

    // R4: write to register 0 discarded
    wr(4, 0, 32'hFFFF_FFFF, '0);
    rd2(4, 0, 0);
    check("R4 r0 data", {rd_a_data, rd_b_data}, 64'd0);
    check("R4 r0 flags", {rd_a_ce, rd_a_ue, rd_b_ce, rd_b_ue}, 64'd0);

    // R6: read and write to the same entry in the same cycle
    @(negedge clk);
    cwp = 3'd2; rd_a_reg = 5'd17; rd_b_reg = 5'd18;
    wr_en = 1'b1; wr_reg = 5'd17; wr_data = 32'h1234_5678;
    @(negedge clk);
    wr_en = 1'b0;
    check("R6 old value on collision", rd_a_data, model[key(2, 17)]);
    @(negedge clk);
    check("R6 new value next cycle", rd_a_data, 32'h1234_5678);
    model[key(2, 17)] = 32'h1234_5678;

    // R7: single flip in each of 39 positions
    for (int b = 0; b < 39; b++) begin
      logic [31:0] d;
      d = 32'hA5C3_0F1E ^ 32'(b * 32'h0101_0101);
      wr(3, 20, d, 39'd1 << b);
      rd2(3, 20, 20);
      check($sformatf("R7 corrected bit %0d", b), {rd_a_data, rd_b_data}, {d, d});
      check($sformatf("R7 flags bit %0d", b), {rd_a_ce, rd_a_ue, rd_b_ce, rd_b_ue}, 64'b1010);
    end

    // R8: two flips
    for (int b = 0; b < 39; b++) begin
      wr(3, 20, 32'h0F0F_3355, (39'd1 << b) | (39'd1 << ((b + 13) % 39)));
      rd2(3, 20, 20);
      check($sformatf("R8 double bits %0d", b), {rd_a_ce, rd_a_ue, rd_b_ce, rd_b_ue}, 64'b0101);
    end

    // R9: clean rewrite clears flags
    wr(3, 20, 32'h7777_1111, '0);
    rd2(3, 20, 20);
    check("R9 rewrite clean", {rd_a_ce, rd_a_ue, rd_b_ce, rd_b_ue}, 64'd0);
    check("R9 rewrite data", rd_a_data, 32'h7777_1111);

    // R10: reset clears populated storage
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R10 outputs after late reset", {rd_a_data, rd_b_data}, 64'd0);
    rd2(6, 9, 21);
    check("R10 storage after late reset", {rd_a_data, rd_b_data}, 64'd0);
    rd2(1, 3, 31);
    check("R10 global after late reset", {rd_a_data, rd_b_data}, 64'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule